// File: doc/BRIEF.md
# Daisy-Chainable SPI Sensor Slave

This block is the serial front end of a position sensor. It serves an SPI master in mode 0: the master samples on rising SCLK, and the slave changes MISO on falling SCLK. Each frame starts with an opcode byte. One command sets two enables for this slave, one for register traffic and one for the sensor-data channel. One command reads out a sensor snapshot. Two commands return an eight-bit status word. A command that is unknown, or that targets a disabled channel, is refused: the slave flags an error and behaves like a wire from MOSI to MISO for the rest of the frame.

The SPI pins are sampled by the system clock and are assumed to be synchronous to it already. While the select is low, the response seen by the master lags the command stream by one SCLK period. For the first eight bits the slave returns the opcode. The selected payload, if any, then replaces the following bits. After the payload the slave forwards MOSI again. Because of this, several slaves can be chained MISO-to-MOSI and share one activation byte.

The block keeps a snapshot of the parallel sensor input, taken on the first SCLK rise of the frame. If that sample was flagged invalid, the readout is all zeros.

Top module: `daisy_spi_slave`

## Requirements
- R1: After reset, both enables (reg_active, data_active) read 1, the status word reads 0x00 and MISO reads 0.
- R2: Opcode 0xB0 takes the second byte of the frame as the activation vector. On the 16th SCLK rise, reg_active is loaded from vector bit 2*SLAVE_IDX+1 and data_active from bit 2*SLAVE_IDX. The other bits are ignored. A frame that ends before the 16th rise leaves both enables unchanged.
- R3: A completed 0xB0 frame clears FAIL (bit 1), VALID (bit 2), BUSY (bit 3) and DISMISS (bit 4) of the status word, and leaves ERROR (bit 0) as it was. Bits 7:5 are always 0.
- R4: The master sees the eight opcode bits returned one SCLK period late. Bit j of the response stream equals bit j of the MOSI stream for j < 8.
- R5: Opcode 0xA6 with data_active=1 returns SD_BITS bits, MSB first, at response positions 8 onward. The value is the sensor input captured on the first SCLK rise of the frame. Later changes of that input have no effect.
- R6: For 0xA6, a capture with sd_valid=0 reads as all zeros and sets ERROR=1, FAIL=1, VALID=0. A valid capture sets ERROR=0, FAIL=0, VALID=1.
- R7: Opcode 0xA6 or 0xF5 with data_active=0 sets ERROR, and the whole response stream equals the MOSI stream.
- R8: Opcode 0xAD with reg_active=0 sets ERROR, and the whole response stream equals the MOSI stream.
- R9: Opcode 0xF5 (needs data_active) and opcode 0xAD (needs reg_active) clear ERROR and return the updated status word at response bits 8 to 15. 0xF5 also sets BUSY when sd_valid is low at the end of the opcode byte.
- R10: Any other opcode sets ERROR, and the response stream equals the MOSI stream.
- R11: After its own payload, the slave again forwards MOSI, so response bit j equals MOSI bit j.
- R12: While ncs is high, MISO is 0 and the bit count is cleared, so every frame is decoded from its first bit.
- R13: DISMISS is set when a frame whose captured sample was valid carries an opcode other than 0xA6 and 0xB0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ncs | input | 1 | Slave select, active low |
| sclk | input | 1 | Serial clock (mode 0) |
| mosi | input | 1 | Serial data from master or upstream |
| miso | output | 1 | Serial data to master or downstream |
| sd_data | input | 8*SD_BYTES | Parallel sensor value |
| sd_valid | input | 1 | Sensor value is valid |
| reg_active | output | 1 | Register-channel enable |
| data_active | output | 1 | Sensor-data-channel enable |
| status | output | 8 | Status word: DISMISS, BUSY, VALID, FAIL, ERROR in bits 4..0 |

## Verification
The bench writes a new sensor value after the first SCLK rise of a readout. A design that captured late would shift out the new value instead of the snapshot. It sends an activation byte with noise outside this slave's pair. A slave that took the wrong pair, or used left alignment, would end up with the wrong enables. It also cuts an activation frame short after twelve bits, which a design that latched on a partial byte would wrongly act on. Refused and unknown opcodes are checked for an exact echo of the MOSI stream, which catches a design that drives stale payload bits. The status sequence checks that ERROR survives an activation while the other four flags are cleared.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam logic [7:0] OP_ACTIVATE = 8'hB0;
    localparam logic [7:0] OP_SD_READ  = 8'hA6;
    localparam logic [7:0] OP_SD_STAT  = 8'hF5;
    localparam logic [7:0] OP_REG_STAT = 8'hAD;

    typedef struct packed {
        logic [2:0] spare;
        logic       dismiss;
        logic       busy;
        logic       valid;
        logic       fail;
        logic       error;
    } stat_t;

    typedef enum logic [1:0] {
        M_HEAD = 2'd0,
        M_SEND = 2'd1,
        M_ACT  = 2'd2,
        M_PASS = 2'd3
    } mode_e;

    // pair for one slave: {register enable, data enable}
    function automatic logic [1:0] pick_pair(input logic [7:0] vec, input int idx);
        return vec[2*idx +: 2];
    endfunction

endpackage

// File: rtl/spi_slv_front.sv
module spi_slv_front #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ncs,
    input  logic             sclk,
    input  logic             mosi,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] cnt,
    output logic             rx_bit,
    output logic [7:0]       byte_now
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             sclk_q;
    logic [6:0]       rx_sr;
    logic [CNT_W-1:0] cnt_q;

    assign rise     = !ncs && sclk && !sclk_q;
    assign fall     = !ncs && !sclk && sclk_q;
    assign cnt      = cnt_q;
    assign byte_now = {rx_sr, mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            rx_sr  <= '0;
            cnt_q  <= '0;
            rx_bit <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (ncs) begin
                rx_sr  <= '0;
                cnt_q  <= '0;
                rx_bit <= 1'b0;
            end else if (rise) begin
                rx_sr  <= {rx_sr[5:0], mosi};
                rx_bit <= mosi;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R12: deselect clears the count
    a_r12_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        ncs |=> cnt_q == '0);

endmodule

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
    import spi_slv_pkg::*;
#(
    parameter int SD_BITS   = 24,
    parameter int SLAVE_IDX = 1,
    parameter int CNT_W     = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ncs,
    input  logic               rise,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [7:0]         byte_now,
    input  logic [SD_BITS-1:0] sd_data,
    input  logic               sd_valid,
    output mode_e              mode,
    output logic               load,
    output logic [SD_BITS-1:0] pay,
    output logic [CNT_W-1:0]   pay_len,
    output stat_t              stat,
    output logic               reg_en,
    output logic               data_en
);
    localparam logic [CNT_W-1:0] AT_FIRST = CNT_W'(0);
    localparam logic [CNT_W-1:0] AT_OP    = CNT_W'(7);
    localparam logic [CNT_W-1:0] AT_VEC   = CNT_W'(15);

    stat_t              stat_q, stat_nx;
    mode_e              mode_q, mode_nx;
    logic [SD_BITS-1:0] snap;
    logic               snap_ok;
    logic               act_fire;

    assign load     = rise && (cnt == AT_OP);
    assign act_fire = rise && (cnt == AT_VEC) && (mode_q == M_ACT);
    assign mode     = mode_q;
    assign stat     = stat_q;

    always_comb begin
        stat_nx = stat_q;
        mode_nx = M_PASS;
        pay_len = '0;
        pay     = '0;
        unique case (byte_now)
            OP_ACTIVATE: mode_nx = M_ACT;
            OP_SD_READ: begin
                if (data_en) begin
                    mode_nx       = M_SEND;
                    pay_len       = CNT_W'(SD_BITS);
                    pay           = snap_ok ? snap : '0;
                    stat_nx.error = !snap_ok;
                    stat_nx.fail  = !snap_ok;
                    stat_nx.valid = snap_ok;
                end else begin
                    stat_nx.error = 1'b1;
                end
            end
            OP_SD_STAT: begin
                if (data_en) begin
                    mode_nx       = M_SEND;
                    pay_len       = CNT_W'(8);
                    stat_nx.error = 1'b0;
                    stat_nx.busy  = !sd_valid;
                end else begin
                    stat_nx.error = 1'b1;
                end
            end
            OP_REG_STAT: begin
                if (reg_en) begin
                    mode_nx       = M_SEND;
                    pay_len       = CNT_W'(8);
                    stat_nx.error = 1'b0;
                end else begin
                    stat_nx.error = 1'b1;
                end
            end
            default: stat_nx.error = 1'b1;
        endcase
        if (snap_ok && byte_now != OP_ACTIVATE && byte_now != OP_SD_READ)
            stat_nx.dismiss = 1'b1;
        stat_nx.spare = '0;
        if (mode_nx == M_SEND && byte_now != OP_SD_READ)
            pay = SD_BITS'(stat_nx) << (SD_BITS - 8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            mode_q  <= M_HEAD;
            snap    <= '0;
            snap_ok <= 1'b0;
            reg_en  <= 1'b1;
            data_en <= 1'b1;
        end else if (ncs) begin
            mode_q <= M_HEAD;
        end else if (rise) begin
            if (cnt == AT_FIRST) begin
                snap    <= sd_data;
                snap_ok <= sd_valid;
            end
            if (load) begin
                stat_q <= stat_nx;
                mode_q <= mode_nx;
            end
            if (act_fire) begin
                {reg_en, data_en} <= pick_pair(byte_now, SLAVE_IDX);
                stat_q.fail    <= 1'b0;
                stat_q.valid   <= 1'b0;
                stat_q.busy    <= 1'b0;
                stat_q.dismiss <= 1'b0;
            end
        end
    end

    // R2: enables move only on a completed activation byte
    a_r2_pair_hold: assert property (@(posedge clk) disable iff (rst)
        !act_fire |=> $stable({reg_en, data_en}));
    // R3: activation clears the four flags
    a_r3_act_clear: assert property (@(posedge clk) disable iff (rst)
        act_fire |=> !stat_q.fail && !stat_q.valid && !stat_q.busy && !stat_q.dismiss);
    // R7 / R8 / R10: a refused frame always carries ERROR
    a_r7_pass_err: assert property (@(posedge clk) disable iff (rst)
        mode_q == M_PASS |-> stat_q.error);
    // R6: readout of a bad capture is flagged
    a_r6_bad_flag: assert property (@(posedge clk) disable iff (rst)
        load && byte_now == OP_SD_READ && data_en && !snap_ok |=> stat_q.error && stat_q.fail);

endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx
    import spi_slv_pkg::*;
#(
    parameter int SD_BITS = 24,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ncs,
    input  logic               load,
    input  logic [SD_BITS-1:0] pay,
    input  logic [CNT_W-1:0]   pay_len,
    input  mode_e              mode,
    input  logic               fall,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               rx_bit,
    output logic               miso
);
    localparam logic [CNT_W-1:0] HDR = CNT_W'(8);

    logic [SD_BITS-1:0] tx_sr;
    logic [CNT_W-1:0]   len_q;
    logic               miso_q;
    logic               sending;

    assign sending = (mode == M_SEND) && (cnt > HDR) && (cnt <= HDR + len_q);
    assign miso    = ncs ? 1'b0 : miso_q;

    always_ff @(posedge clk) begin
        if (rst || ncs) begin
            tx_sr  <= '0;
            len_q  <= '0;
            miso_q <= 1'b0;
        end else begin
            if (load) begin
                tx_sr <= pay;
                len_q <= pay_len;
            end
            if (fall) begin
                if (sending) begin
                    miso_q <= tx_sr[SD_BITS-1];
                    tx_sr  <= tx_sr << 1;
                end else begin
                    miso_q <= rx_bit;
                end
            end
        end
    end

    // R11 / R4: outside a payload the line forwards the last received bit
    a_r11_forward: assert property (@(posedge clk) disable iff (rst)
        fall && mode != M_SEND |=> miso == $past(rx_bit));

endmodule

// File: rtl/daisy_spi_slave.sv
module daisy_spi_slave
    import spi_slv_pkg::*;
#(
    parameter int SD_BYTES  = 3,
    parameter int SLAVE_IDX = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ncs,
    input  logic                  sclk,
    input  logic                  mosi,
    output logic                  miso,
    input  logic [8*SD_BYTES-1:0] sd_data,
    input  logic                  sd_valid,
    output logic                  reg_active,
    output logic                  data_active,
    output logic [7:0]            status
);
    localparam int SD_BITS = 8 * SD_BYTES;
    localparam int CNT_W   = $clog2(SD_BITS + 24) + 1;

    logic               rise, fall, rx_bit, load;
    logic [CNT_W-1:0]   cnt, pay_len;
    logic [7:0]         byte_now;
    logic [SD_BITS-1:0] pay;
    mode_e              mode;
    stat_t              stat;

    spi_slv_front #(.CNT_W(CNT_W)) u_front (
        .clk(clk), .rst(rst), .ncs(ncs), .sclk(sclk), .mosi(mosi),
        .rise(rise), .fall(fall), .cnt(cnt), .rx_bit(rx_bit), .byte_now(byte_now)
    );

    spi_slv_ctrl #(.SD_BITS(SD_BITS), .SLAVE_IDX(SLAVE_IDX), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .ncs(ncs), .rise(rise), .cnt(cnt), .byte_now(byte_now),
        .sd_data(sd_data), .sd_valid(sd_valid), .mode(mode), .load(load), .pay(pay),
        .pay_len(pay_len), .stat(stat), .reg_en(reg_active), .data_en(data_active)
    );

    spi_slv_tx #(.SD_BITS(SD_BITS), .CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst(rst), .ncs(ncs), .load(load), .pay(pay), .pay_len(pay_len),
        .mode(mode), .fall(fall), .cnt(cnt), .rx_bit(rx_bit), .miso(miso)
    );

    assign status = stat;

    // R1: reset state of the enables and flags
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> reg_active && data_active && status == 8'h00);

endmodule

// File: tb/test_daisy_spi_slave.sv
module test_daisy_spi_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ncs = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [23:0] sd_data = '0;
    logic        sd_valid = 1'b0;
    logic        reg_active, data_active;
    logic [7:0]  status;

    int total = 0;
    int bad = 0;
    logic        alt_en = 1'b0;
    logic [23:0] alt_sd = '0;
    logic [63:0] rx;

    always #10 clk = ~clk;

    daisy_spi_slave i_daisy_spi_slave (
        .clk(clk), .rst(rst), .ncs(ncs), .sclk(sclk), .mosi(mosi), .miso(miso),
        .sd_data(sd_data), .sd_valid(sd_valid), .reg_active(reg_active),
        .data_active(data_active), .status(status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stream is MSB-first in tx[nbits-1:0]; response returned the same way
    task automatic xfer(input logic [63:0] tx, input int nbits, output logic [63:0] res);
        res = '0;
        @(negedge clk);
        ncs = 1'b0;
        repeat (4) @(negedge clk);
        for (int e = 1; e <= nbits + 1; e++) begin
            mosi = (e <= nbits) ? tx[nbits - e] : 1'b0;
            repeat (4) @(negedge clk);
            if (e >= 2) res[nbits - e + 1] = miso;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            if (e == 1 && alt_en) sd_data = alt_sd;
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ncs = 1'b1;
        mosi = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reg_active", {63'd0, reg_active}, 64'd1);
        chk("R1 data_active", {63'd0, data_active}, 64'd1);
        chk("R1 status", {56'd0, status}, 64'h00);
        chk("R1 miso", {63'd0, miso}, 64'd0);
    endtask

    task automatic t_read_valid;
        sd_data = 24'hA5C33C; sd_valid = 1'b1;
        alt_en = 1'b1; alt_sd = 24'h0F0F0F;
        xfer({24'd0, 8'hA6, 24'h0, 8'h5A}, 40, rx);
        alt_en = 1'b0;
        chk("R4 R5 R11 readout stream", rx, {24'd0, 8'hA6, 24'hA5C33C, 8'h5A});
        chk("R6 status after valid read", {56'd0, status}, 64'h04);
    endtask

    task automatic t_read_invalid;
        sd_data = 24'h777777; sd_valid = 1'b0;
        xfer({24'd0, 8'hA6, 24'h0, 8'hC3}, 40, rx);
        chk("R6 invalid read zeros", rx, {24'd0, 8'hA6, 24'h0, 8'hC3});
        chk("R6 status after invalid read", {56'd0, status}, 64'h03);
    endtask

    task automatic t_sd_status;
        xfer({40'd0, 8'hF5, 8'h00, 8'hC3}, 24, rx);
        chk("R9 sensor status stream", rx, {40'd0, 8'hF5, 8'h0A, 8'hC3});
        chk("R9 busy set", {56'd0, status}, 64'h0A);
    endtask

    task automatic t_reg_status;
        sd_valid = 1'b1;
        xfer({40'd0, 8'hAD, 8'h00, 8'h81}, 24, rx);
        chk("R9 R13 register status stream", rx, {40'd0, 8'hAD, 8'h1A, 8'h81});
        chk("R13 dismiss set", {56'd0, status}, 64'h1A);
    endtask

    task automatic t_unknown;
        xfer({40'd0, 8'h3C, 8'h96, 8'h0F}, 24, rx);
        chk("R10 unknown echoes", rx, {40'd0, 8'h3C, 8'h96, 8'h0F});
        chk("R10 error set", {56'd0, status}, 64'h1B);
    endtask

    task automatic t_activate(input logic [7:0] vec, input logic r_exp, input logic d_exp,
                              input logic [7:0] st_exp);
        xfer({48'd0, 8'hB0, vec}, 16, rx);
        chk("R2 activate echoes", rx, {48'd0, 8'hB0, vec});
        chk("R2 reg_active", {63'd0, reg_active}, {63'd0, r_exp});
        chk("R2 data_active", {63'd0, data_active}, {63'd0, d_exp});
        chk("R3 flags cleared, error kept", {56'd0, status}, {56'd0, st_exp});
    endtask

    task automatic t_reg_disabled;
        xfer({40'd0, 8'hAD, 8'h00, 8'h55}, 24, rx);
        chk("R8 refused register echoes", rx, {40'd0, 8'hAD, 8'h00, 8'h55});
        chk("R8 error set", {56'd0, status}, 64'h11);
    endtask

    task automatic t_data_disabled;
        xfer({24'd0, 8'hA6, 24'h123456, 8'h99}, 40, rx);
        chk("R7 refused readout echoes", rx, {24'd0, 8'hA6, 24'h123456, 8'h99});
        chk("R7 error after readout", {56'd0, status}, 64'h01);
        xfer({40'd0, 8'hF5, 8'hE7, 8'h18}, 24, rx);
        chk("R7 refused status echoes", rx, {40'd0, 8'hF5, 8'hE7, 8'h18});
        chk("R7 error after status", {56'd0, status}, 64'h11);
    endtask

    task automatic t_short_activate;
        xfer({52'd0, 8'hB0, 4'hF}, 12, rx);
        chk("R2 R12 short activate keeps reg", {63'd0, reg_active}, 64'd1);
        chk("R2 R12 short activate keeps data", {63'd0, data_active}, 64'd0);
        chk("R12 status unchanged", {56'd0, status}, 64'h11);
        chk("R12 miso idle", {63'd0, miso}, 64'd0);
    endtask

    task automatic t_restore;
        t_activate(8'h0C, 1'b1, 1'b1, 8'h01);
        sd_data = 24'h123456; sd_valid = 1'b1;
        xfer({24'd0, 8'hA6, 24'h0, 8'hFF}, 40, rx);
        chk("R5 R11 readout after restore", rx, {24'd0, 8'hA6, 24'h123456, 8'hFF});
        chk("R6 status after restore read", {56'd0, status}, 64'h04);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_read_valid();
        t_read_invalid();
        t_sd_status();
        t_reg_status();
        t_unknown();
        t_activate(8'b1010_0110, 1'b0, 1'b1, 8'h01);
        t_reg_disabled();
        t_activate(8'b0101_1001, 1'b1, 1'b0, 8'h01);
        t_data_disabled();
        t_short_activate();
        t_restore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule